// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a segment/offset pair into a 20-bit physical byte address in the style of the classic real-mode scheme: the 16-bit segment value is scaled by sixteen and the 16-bit offset is added to it. Four 16-bit segment registers are kept inside the block: extra, code, stack and data. Software-visible state outside the block loads them through a simple write port.

A caller raises a request strobe together with an access class and a pointer. The class picks the default segment: instruction fetches use the code segment, stack-pointer or base-pointer accesses use the stack segment, and ordinary operand accesses use the data segment. An override enable with a 2-bit segment index replaces that default. The pointer input is 32 bits wide, but only its low 16 bits serve as the offset. Sums that pass the top of the 1 MB space wrap back to zero. The result is registered and appears one cycle after the request, marked by a one-cycle valid pulse.

Top module: `seg_addr_gen`

## Requirements
- R1: On synchronous reset, pa_valid is 0, pa is 00000H, and all four segment registers hold 0000H.
- R2: The physical address equals segment*16 + offset. For any segment S, offsets 0000H..FFFFH reach S*16 through S*16+FFFFH, a 64 KB window.
- R3: The sum is taken modulo 2^20, so it wraps past FFFFFH. For example, segment FFFFH with offset 0010H gives 00000H, and with offset 000FH gives FFFFFH.
- R4: Access class 0 (fetch) selects the code segment by default.
- R5: Access class 1 (stack or base pointer) selects the stack segment by default.
- R6: Access classes 2 and 3 (plain data) select the data segment by default.
- R7: When ovr_en is 1, ovr_idx picks the segment in place of the default. When ovr_en is 0, ovr_idx has no effect.
- R8: Only ptr[15:0] forms the offset. The value of ptr[31:16] has no effect on pa.
- R9: Segment index encoding is 0 = extra, 1 = code, 2 = stack, 3 = data. A write takes effect at the next clock edge. A request in the same cycle as a write uses the old value.
- R10: pa_valid is 1 in exactly the cycle after each cycle with req_valid=1. pa updates only then and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Segment register write enable |
| wr_idx | input | 2 | Segment register index to write |
| wr_data | input | 16 | Value to write |
| req_valid | input | 1 | Address request strobe |
| req_class | input | 2 | Access class: 0 fetch, 1 stack, 2/3 data |
| ovr_en | input | 1 | Segment override enable |
| ovr_idx | input | 2 | Override segment index |
| ptr | input | 32 | Offset pointer (low 16 bits used) |
| pa_valid | output | 1 | Physical address valid pulse |
| pa | output | 20 | Registered physical address |

## Verification
The bench loads each segment register with a distinct value so that a wrong segment choice shows up as a wrong address for every access class. It also checks the override path, including override against an unrelated default. Pointers with non-zero upper halves separate correct truncation from full-width use. Segment values near FFFFH, paired with offsets at both ends of the window, separate wrap-around from carry into a 21st bit. A write issued in the same cycle as a request tells old-value from new-value forwarding. A pseudo-random sweep over all classes covers the arithmetic more broadly.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    localparam int SEG_W_D = 16;
    localparam int OFF_W_D = 16;
    localparam int PA_W_D  = 20;
    localparam int PTR_W_D = 32;
    localparam int SHIFT_D = 4;

    typedef enum logic [1:0] {
        SEG_EXTRA = 2'd0,
        SEG_CODE  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_DATA  = 2'd3
    } seg_id_e;

    typedef enum logic [1:0] {
        ACC_FETCH    = 2'd0,
        ACC_STACK    = 2'd1,
        ACC_DATA     = 2'd2,
        ACC_DATA_ALT = 2'd3
    } acc_class_e;

    typedef struct packed {
        acc_class_e cls;
        logic       ovr_en;
        seg_id_e    ovr_seg;
    } seg_req_t;

    function automatic seg_id_e default_seg(acc_class_e c);
        case (c)
            ACC_FETCH: return SEG_CODE;
            ACC_STACK: return SEG_STACK;
            default:   return SEG_DATA;
        endcase
    endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
    parameter int SEG_W   = 16,
    parameter int NUM_SEG = 4,
    localparam int IDX_W  = $clog2(NUM_SEG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SEG_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [SEG_W-1:0] rd_data
);
    logic [SEG_W-1:0] seg_q [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst)
                seg_q[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                seg_q[g] <= wr_data;
        end
    end

    assign rd_data = seg_q[rd_idx];

    // R9: a write lands in the addressed register at the next edge
    p_write_lands_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (seg_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_addr_pkg::*;
(
    input  seg_req_t req,
    output seg_id_e  sel
);
    seg_id_e dflt;

    always_comb begin
        dflt = default_seg(req.cls);
        sel  = req.ovr_en ? req.ovr_seg : dflt;
    end

endmodule

// File: rtl/seg_addr_adder.sv
module seg_addr_adder #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int PA_W  = 20,
    parameter int SHIFT = 4
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  pa
);
    localparam int BASE_W = SEG_W + SHIFT;

    logic [BASE_W-1:0] base;

    always_comb begin
        base = {seg, {SHIFT{1'b0}}};
        pa   = PA_W'(base) + PA_W'(off);
    end

    // R2: the low SHIFT bits come from the offset alone
    always_comb begin
        p_low_bits_r2: assert (pa[SHIFT-1:0] == off[SHIFT-1:0]);
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = SEG_W_D,
    parameter int OFF_W = OFF_W_D,
    parameter int PA_W  = PA_W_D,
    parameter int PTR_W = PTR_W_D,
    parameter int SHIFT = SHIFT_D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_idx,
    input  logic [SEG_W-1:0] wr_data,
    input  logic             req_valid,
    input  logic [1:0]       req_class,
    input  logic             ovr_en,
    input  logic [1:0]       ovr_idx,
    input  logic [PTR_W-1:0] ptr,
    output logic             pa_valid,
    output logic [PA_W-1:0]  pa
);
    seg_req_t         req;
    seg_id_e          sel_seg;
    logic [SEG_W-1:0] seg_val;
    logic [OFF_W-1:0] offset;
    logic [PA_W-1:0]  pa_next;
    logic [PA_W-1:0]  pa_q;
    logic             valid_q;

    always_comb begin
        req.cls     = acc_class_e'(req_class);
        req.ovr_en  = ovr_en;
        req.ovr_seg = seg_id_e'(ovr_idx);
        offset      = OFF_W'(ptr);
    end

    seg_select u_sel (
        .req (req),
        .sel (sel_seg)
    );

    seg_regfile #(.SEG_W(SEG_W), .NUM_SEG(4)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (sel_seg),
        .rd_data (seg_val)
    );

    seg_addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .SHIFT(SHIFT)) u_add (
        .seg (seg_val),
        .off (offset),
        .pa  (pa_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pa_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= req_valid;
            if (req_valid)
                pa_q <= pa_next;
        end
    end

    assign pa       = pa_q;
    assign pa_valid = valid_q;

    // R10: one valid pulse per request, in the following cycle
    p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> pa_valid);
    p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !pa_valid);
    // R10: address holds between requests
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(pa));
    // R7: an enabled override decides the segment
    p_override_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ovr_en) |-> (sel_seg == seg_id_e'(ovr_idx)));

endmodule

// File: tb/sim_seg_addr_gen.sv
`timescale 1ns/1ps
module sim_seg_addr_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_idx;
    logic [15:0] wr_data;
    logic        req_valid;
    logic [1:0]  req_class;
    logic        ovr_en;
    logic [1:0]  ovr_idx;
    logic [31:0] ptr;
    logic        pa_valid;
    logic [19:0] pa;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [19:0] exp;
        string       tag;
    } item_t;

    item_t       sb[$];
    logic [15:0] shadow [4];
    logic [19:0] last_pa;

    always #2.5 clk = ~clk;

    seg_addr_gen u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .req_valid(req_valid), .req_class(req_class), .ovr_en(ovr_en),
        .ovr_idx(ovr_idx), .ptr(ptr), .pa_valid(pa_valid), .pa(pa)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus; pushes an expected item when a request is made
    task automatic drive(input bit rq, input logic [1:0] cls, input bit oe,
                         input logic [1:0] oi, input logic [31:0] p,
                         input bit we, input logic [1:0] wi, input logic [15:0] wd,
                         input string tag);
        item_t it;
        logic [1:0]  s;
        @(negedge clk);
        req_valid = rq; req_class = cls; ovr_en = oe; ovr_idx = oi; ptr = p;
        wr_en = we; wr_idx = wi; wr_data = wd;
        if (rq) begin
            if (oe) s = oi;
            else if (cls == 2'd0) s = 2'd1;
            else if (cls == 2'd1) s = 2'd2;
            else s = 2'd3;
            it.exp = {shadow[s], 4'h0} + {4'h0, p[15:0]};
            it.tag = tag;
            sb.push_back(it);
        end
        if (we) shadow[wi] = wd;
    endtask

    task automatic idle();
        drive(1'b0, 2'd0, 1'b0, 2'd0, 32'h0, 1'b0, 2'd0, 16'h0, "");
    endtask

    task automatic wr(input logic [1:0] i, input logic [15:0] d);
        drive(1'b0, 2'd0, 1'b0, 2'd0, 32'h0, 1'b1, i, d, "");
    endtask

    task automatic rq(input logic [1:0] cls, input logic [31:0] p, input string tag);
        drive(1'b1, cls, 1'b0, 2'd0, p, 1'b0, 2'd0, 16'h0, tag);
    endtask

    // monitor: scoreboard pop shortly after each rising edge
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            check(pa_valid == (sb.size() != 0), "R10 valid pulse", {31'd0, pa_valid}, {31'd0, sb.size() != 0});
            if (pa_valid && sb.size() != 0) begin
                item_t it;
                it = sb.pop_front();
                check(pa == it.exp, it.tag, {12'd0, pa}, {12'd0, it.exp});
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        for (int i = 0; i < 4; i++) shadow[i] = 16'h0;
        rst = 1'b1; wr_en = 0; wr_idx = 0; wr_data = 0; req_valid = 0;
        req_class = 0; ovr_en = 0; ovr_idx = 0; ptr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(pa_valid == 1'b0, "R1 reset valid", {31'd0, pa_valid}, 32'd0);
        check(pa == 20'h0, "R1 reset pa", {12'd0, pa}, 32'd0);
        rq(2'd2, 32'h0000_1234, "R1 reset segment zero");
        rq(2'd0, 32'h0000_0042, "R1 reset code segment zero");
        idle();

        wr(2'd0, 16'h4000);
        wr(2'd1, 16'h1000);
        wr(2'd2, 16'h3000);
        wr(2'd3, 16'h2000);
        rq(2'd0, 32'h0000_0100, "R4 fetch uses code");
        rq(2'd1, 32'h0000_0FF0, "R5 stack uses stack");
        rq(2'd2, 32'h0000_0ABC, "R6 data class 2");
        rq(2'd3, 32'h0000_0ABD, "R6 data class 3");
        drive(1'b1, 2'd0, 1'b1, 2'd0, 32'h0000_0005, 1'b0, 2'd0, 16'h0, "R7 override fetch to extra");
        drive(1'b1, 2'd1, 1'b1, 2'd3, 32'h0000_0006, 1'b0, 2'd0, 16'h0, "R7 override stack to data");
        drive(1'b1, 2'd2, 1'b0, 2'd0, 32'h0000_0007, 1'b0, 2'd0, 16'h0, "R7 override index ignored");
        rq(2'd2, 32'hABCD_FFFF, "R8 upper pointer ignored");
        rq(2'd1, 32'hFFFF_0000, "R8 upper pointer ignored stack");
        idle();
        idle();
        last_pa = pa;
        @(negedge clk);
        check(pa == last_pa, "R10 hold when idle", {12'd0, pa}, {12'd0, last_pa});

        wr(2'd3, 16'hFFFF);
        rq(2'd2, 32'h0000_0010, "R3 wrap to zero");
        rq(2'd2, 32'h0000_000F, "R3 top address");
        rq(2'd2, 32'h0000_FFFF, "R3 wrap high offset");
        wr(2'd3, 16'h1234);
        rq(2'd2, 32'h0000_0000, "R2 window start");
        rq(2'd2, 32'h0000_FFFF, "R2 window end");

        drive(1'b1, 2'd2, 1'b0, 2'd0, 32'h0000_0001, 1'b1, 2'd3, 16'h5555, "R9 same cycle old value");
        rq(2'd2, 32'h0000_0001, "R9 new value next cycle");
        drive(1'b1, 2'd0, 1'b0, 2'd0, 32'h0000_0002, 1'b1, 2'd1, 16'h0777, "R9 code old value");
        rq(2'd0, 32'h0000_0002, "R9 code new value");

        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (i % 5 == 0) wr(lfsr[1:0], lfsr[31:16]);
            drive(1'b1, lfsr[3:2], lfsr[4] & lfsr[9], lfsr[6:5], {lfsr[15:0], lfsr[31:16]},
                  1'b0, 2'd0, 16'h0, "R2 sweep");
            if (lfsr[7]) idle();
        end
        idle();
        idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule